// File: doc/BRIEF.md
# Twelve-Bit Instruction Decoder

This block turns one 12-bit instruction word into the control signals of an 8-bit accumulator datapath that has a working register W and a register file. It is purely combinational. It reports the ALU operation, the operand source for each ALU input, and four write strobes: one for W, one for the addressed file register, one for the zero flag and one for the carry flag. Program-counter sequencing is handled elsewhere.

Byte-oriented instructions carry a destination bit d at position 5 and a 5-bit file address in bits [4:0]. Literal instructions carry an 8-bit constant in bits [7:0]. The decoder is built as a list of mask/pattern entries. Each entry is matched in parallel, and the single matching entry's control word is selected. An instruction that matches no entry produces a quiet no-op, so neither the register file nor the flags can change.

Top module: `instr_decoder`

## Requirements
- R1: For byte-oriented instructions, bit 5 (d) selects the destination: d=0 asserts only `we_w_o` and d=1 asserts only `we_f_o`. `we_w_o` and `we_f_o` are never high together, and `we_f_o` is never high when bit 5 is 0.
- R2: The ALU operation codes are ADD=0, SUB=1, XOR=4, ROR=6, ROL=7, SWAP=8 and PASS=9, where PASS forwards input A. The source select codes are W=0, FILE=1, LIT=2 and NONE=3.
- R3: An instruction with bits [11:6]=001101 (rotate left through carry) gives op ROL, A=FILE, B=NONE, a destination chosen by d, `we_c_o`=1 and `we_z_o`=0.
- R4: Bits [11:6]=001100 (rotate right through carry) give op ROR, A=FILE, B=NONE, a destination chosen by d, `we_c_o`=1 and `we_z_o`=0.
- R5: Bits [11:6]=001110 (nibble swap) give op SWAP, A=FILE, B=NONE, a destination chosen by d, and no flag enables.
- R6: Bits [11:6]=001000 (move file) give op PASS, A=FILE, B=NONE, a destination chosen by d, `we_z_o`=1 and `we_c_o`=0.
- R7: Bits [11:6]=000111 (add W and file) give op ADD, A=W, B=FILE, a destination chosen by d, and both flag enables set.
- R8: Bits [11:6]=000010 (subtract W from file) give op SUB, A=FILE, B=W, a destination chosen by d, and both flag enables set.
- R9: Bits [11:8]=1111 (XOR literal into W) give op XOR, A=W, B=LIT, `we_w_o`=1, `we_f_o`=0, `we_z_o`=1 and `we_c_o`=0.
- R10: Bits [11:8]=1100 (load literal) give op PASS, A=LIT, B=NONE, `we_w_o`=1, and no other enable. The LIT source appears only when bits [11:10]=11.
- R11: Any other encoding drives all four write enables to 0, the op to PASS and both selects to NONE.
- R12: Bits [4:0] of byte-oriented words and bits [7:0] of literal words have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 12 | Instruction word |
| alu_op_o | output | 4 | ALU operation code |
| a_sel_o | output | 2 | ALU input A source |
| b_sel_o | output | 2 | ALU input B source |
| we_w_o | output | 1 | Write enable for working register |
| we_f_o | output | 1 | Write enable for addressed file register |
| we_z_o | output | 1 | Write enable for zero flag |
| we_c_o | output | 1 | Write enable for carry flag |

## Verification
The bench builds the decoder with its default 12-bit word and eight-entry table. At that size all 4096 instruction words can be applied one per cycle. Every word is compared against an arithmetic model of the requirements, which covers every unrecognised encoding as well as both values of d. The full sweep also makes the low-bit independence of R12 checkable directly, by comparing the recorded outputs of words that differ only in their address or literal field.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  parameter int unsigned INSTR_W     = 12;
  parameter int unsigned OP_W        = 4;
  parameter int unsigned SEL_W       = 2;
  parameter int unsigned DEST_BIT    = 5;
  parameter int unsigned NUM_ENTRIES = 8;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_COM  = 4'd5,
    ALU_ROR  = 4'd6,
    ALU_ROL  = 4'd7,
    ALU_SWAP = 4'd8,
    ALU_PASS = 4'd9
  } alu_op_e;

  typedef enum logic [SEL_W-1:0] {
    SRC_W    = 2'd0,
    SRC_FILE = 2'd1,
    SRC_LIT  = 2'd2,
    SRC_NONE = 2'd3
  } src_sel_e;

  typedef struct packed {
    alu_op_e  op;
    src_sel_e a_sel;
    src_sel_e b_sel;
    logic     by_dest;  // destination follows d
    logic     to_w;     // always writes W
    logic     upd_z;
    logic     upd_c;
  } ctrl_t;

  typedef struct packed {
    logic [INSTR_W-1:0] mask;
    logic [INSTR_W-1:0] pattern;
    ctrl_t              ctrl;
  } entry_t;

  localparam logic [INSTR_W-1:0] MASK_BYTE = 12'hFC0;
  localparam logic [INSTR_W-1:0] MASK_LIT  = 12'hF00;

  localparam ctrl_t CTRL_NOP = '{op: ALU_PASS, a_sel: SRC_NONE, b_sel: SRC_NONE,
                                 by_dest: 1'b0, to_w: 1'b0, upd_z: 1'b0, upd_c: 1'b0};

  function automatic entry_t mk(logic [INSTR_W-1:0] m, logic [INSTR_W-1:0] p,
                                alu_op_e op, src_sel_e a, src_sel_e b,
                                logic dst, logic w, logic z, logic c);
    entry_t e;
    e.mask          = m;
    e.pattern       = p;
    e.ctrl.op       = op;
    e.ctrl.a_sel    = a;
    e.ctrl.b_sel    = b;
    e.ctrl.by_dest  = dst;
    e.ctrl.to_w     = w;
    e.ctrl.upd_z    = z;
    e.ctrl.upd_c    = c;
    return e;
  endfunction

  // Patterns are mutually exclusive; selection relies on that.
  function automatic entry_t entry_at(int unsigned idx);
    case (idx)
      0: return mk(MASK_BYTE, 12'h080, ALU_SUB,  SRC_FILE, SRC_W,    1'b1, 1'b0, 1'b1, 1'b1);
      1: return mk(MASK_BYTE, 12'h1C0, ALU_ADD,  SRC_W,    SRC_FILE, 1'b1, 1'b0, 1'b1, 1'b1);
      2: return mk(MASK_BYTE, 12'h200, ALU_PASS, SRC_FILE, SRC_NONE, 1'b1, 1'b0, 1'b1, 1'b0);
      3: return mk(MASK_BYTE, 12'h300, ALU_ROR,  SRC_FILE, SRC_NONE, 1'b1, 1'b0, 1'b0, 1'b1);
      4: return mk(MASK_BYTE, 12'h340, ALU_ROL,  SRC_FILE, SRC_NONE, 1'b1, 1'b0, 1'b0, 1'b1);
      5: return mk(MASK_BYTE, 12'h380, ALU_SWAP, SRC_FILE, SRC_NONE, 1'b1, 1'b0, 1'b0, 1'b0);
      6: return mk(MASK_LIT,  12'hC00, ALU_PASS, SRC_LIT,  SRC_NONE, 1'b0, 1'b1, 1'b0, 1'b0);
      7: return mk(MASK_LIT,  12'hF00, ALU_XOR,  SRC_W,    SRC_LIT,  1'b0, 1'b1, 1'b1, 1'b0);
      default: return mk('1, '0, ALU_PASS, SRC_NONE, SRC_NONE, 1'b0, 1'b0, 1'b0, 1'b0);
    endcase
  endfunction
endpackage

// File: rtl/idec_match.sv
module idec_match
  import instr_dec_pkg::*;
#(
  parameter int unsigned N = NUM_ENTRIES
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [N-1:0]       hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam entry_t E = entry_at(g);
    assign hit_o[g] = ((instr_i & E.mask) == E.pattern);
  end
endmodule

// File: rtl/idec_select.sv
module idec_select
  import instr_dec_pkg::*;
#(
  parameter int unsigned N = NUM_ENTRIES
) (
  input  logic [N-1:0] hit_i,
  output ctrl_t        ctrl_o
);
  logic [$bits(ctrl_t)-1:0] acc;

  // One-hot AND-OR; no priority chain
  always_comb begin
    acc = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (hit_i[i]) acc = acc | entry_at(i).ctrl;
    end
    ctrl_o = (|hit_i) ? ctrl_t'(acc) : CTRL_NOP;
  end
endmodule

// File: rtl/idec_enables.sv
module idec_enables
  import instr_dec_pkg::*;
(
  input  ctrl_t            ctrl_i,
  input  logic             d_i,
  output logic [OP_W-1:0]  alu_op_o,
  output logic [SEL_W-1:0] a_sel_o,
  output logic [SEL_W-1:0] b_sel_o,
  output logic             we_w_o,
  output logic             we_f_o,
  output logic             we_z_o,
  output logic             we_c_o
);
  assign alu_op_o = ctrl_i.op;
  assign a_sel_o  = ctrl_i.a_sel;
  assign b_sel_o  = ctrl_i.b_sel;
  assign we_w_o   = ctrl_i.to_w | (ctrl_i.by_dest & ~d_i);
  assign we_f_o   = ctrl_i.by_dest & d_i;
  assign we_z_o   = ctrl_i.upd_z;
  assign we_c_o   = ctrl_i.upd_c;
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
(
  input  logic [11:0] instr_i,
  output logic [3:0]  alu_op_o,
  output logic [1:0]  a_sel_o,
  output logic [1:0]  b_sel_o,
  output logic        we_w_o,
  output logic        we_f_o,
  output logic        we_z_o,
  output logic        we_c_o
);
  logic [NUM_ENTRIES-1:0] hit;
  ctrl_t                  ctrl;

  idec_match #(.N(NUM_ENTRIES)) i_match (
    .instr_i (instr_i),
    .hit_o   (hit)
  );

  idec_select #(.N(NUM_ENTRIES)) i_select (
    .hit_i  (hit),
    .ctrl_o (ctrl)
  );

  idec_enables i_enables (
    .ctrl_i   (ctrl),
    .d_i      (instr_i[DEST_BIT]),
    .alu_op_o (alu_op_o),
    .a_sel_o  (a_sel_o),
    .b_sel_o  (b_sel_o),
    .we_w_o   (we_w_o),
    .we_f_o   (we_f_o),
    .we_z_o   (we_z_o),
    .we_c_o   (we_c_o)
  );
endmodule

// File: rtl/idec_checker.sv
module idec_checker (
  input logic [11:0] instr_i,
  input logic [3:0]  alu_op_o,
  input logic [1:0]  a_sel_o,
  input logic [1:0]  b_sel_o,
  input logic        we_w_o,
  input logic        we_f_o,
  input logic        we_z_o,
  input logic        we_c_o
);
  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_single_dest_r1: assert (!(we_w_o && we_f_o))
        else $error("W and file written together");
      p_file_needs_d_r1: assert (!we_f_o || instr_i[5])
        else $error("file write with d=0");
      p_lit_upper_r10: assert (!(a_sel_o == 2'd2 || b_sel_o == 2'd2) || instr_i[11:10] == 2'b11)
        else $error("literal source outside literal class");
      p_carry_ops_r8: assert (!we_c_o || alu_op_o inside {4'd0, 4'd1, 4'd6, 4'd7})
        else $error("carry update from non-arith op");
      p_nop_quiet_r11: assert (a_sel_o != 2'd3 || (!we_w_o && !we_f_o && !we_z_o && !we_c_o && alu_op_o == 4'd9))
        else $error("no-op not quiet");
      p_zero_pass_r6: assert (!(we_z_o && alu_op_o == 4'd9) || a_sel_o == 2'd1)
        else $error("Z update on pass without file source");
    end
  end
endmodule

bind instr_decoder idec_checker i_chk (
  .instr_i  (instr_i),
  .alu_op_o (alu_op_o),
  .a_sel_o  (a_sel_o),
  .b_sel_o  (b_sel_o),
  .we_w_o   (we_w_o),
  .we_f_o   (we_f_o),
  .we_z_o   (we_z_o),
  .we_c_o   (we_c_o)
);

// File: tb/test_instr_decoder.sv
module test_instr_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] instr = '0;
  logic [3:0]  alu_op;
  logic [1:0]  a_sel, b_sel;
  logic        we_w, we_f, we_z, we_c;

  int checks = 0;
  int errors = 0;
  logic [11:0] seen [4096];
  bit done = 1'b0;

  always #2 clk = ~clk;

  instr_decoder i_instr_decoder (
    .instr_i  (instr),
    .alu_op_o (alu_op),
    .a_sel_o  (a_sel),
    .b_sel_o  (b_sel),
    .we_w_o   (we_w),
    .we_f_o   (we_f),
    .we_z_o   (we_z),
    .we_c_o   (we_c)
  );

  function automatic logic [11:0] pack_out();
    return {alu_op, a_sel, b_sel, we_w, we_f, we_z, we_c};
  endfunction

  // Model from the requirements: {op, a, b, we_w, we_f, we_z, we_c}
  function automatic logic [11:0] model(logic [11:0] w, output string tag);
    logic d = w[5];
    logic [11:0] r;
    case (w[11:6])
      6'b000010: begin r = {4'd1, 2'd1, 2'd0, ~d, d, 1'b1, 1'b1}; tag = "R8 R1 R2"; end
      6'b000111: begin r = {4'd0, 2'd0, 2'd1, ~d, d, 1'b1, 1'b1}; tag = "R7 R1 R2"; end
      6'b001000: begin r = {4'd9, 2'd1, 2'd3, ~d, d, 1'b1, 1'b0}; tag = "R6 R1 R2"; end
      6'b001100: begin r = {4'd6, 2'd1, 2'd3, ~d, d, 1'b0, 1'b1}; tag = "R4 R1 R2"; end
      6'b001101: begin r = {4'd7, 2'd1, 2'd3, ~d, d, 1'b0, 1'b1}; tag = "R3 R1 R2"; end
      6'b001110: begin r = {4'd8, 2'd1, 2'd3, ~d, d, 1'b0, 1'b0}; tag = "R5 R1 R2"; end
      default: begin
        if (w[11:8] == 4'hC) begin r = {4'd9, 2'd2, 2'd3, 4'b1000}; tag = "R10 R2"; end
        else if (w[11:8] == 4'hF) begin r = {4'd4, 2'd0, 2'd2, 4'b1010}; tag = "R9 R2"; end
        else begin r = {4'd9, 2'd3, 2'd3, 4'b0000}; tag = "R11"; end
      end
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [11:0] w, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s instr=%03h actual=%03h expected=%03h", tag, w, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    string tag;
    logic [11:0] exp;
    // Reset-time state with a zero word: quiet no-op (R11)
    @(negedge clk);
    check("R11 reset", instr, pack_out(), {4'd9, 2'd3, 2'd3, 4'b0000});
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // Exhaustive sweep
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      instr = 12'(i);
      @(posedge clk);
      #1;
      exp = model(instr, tag);
      seen[i] = pack_out();
      check(tag, instr, seen[i], exp);
    end

    // R12: address field has no effect on byte-oriented groups
    for (int hi = 0; hi < 128; hi++) begin
      for (int lo = 1; lo < 32; lo += 10) begin
        check("R12 addr", 12'((hi << 5) | lo), seen[(hi << 5) | lo], seen[hi << 5]);
      end
    end
    // R12: literal field has no effect on literal groups
    for (int k = 0; k < 256; k++) begin
      check("R12 lit C", 12'h000 | 12'(12'hC00 + k), seen[12'hC00 + k], seen[12'hC00]);
      check("R12 lit F", 12'h000 | 12'(12'hF00 + k), seen[12'hF00 + k], seen[12'hF00]);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule